// File: doc/BRIEF.md
# Operand Address Generator with Stack Modes

This block turns one operand field of a 16-bit, eight-register machine into a routed operand. Depending on the code, the operand is a general register, a special register (stack pointer, program counter, extra/overflow register), a memory location with a computed effective address, or a constant. The instruction decoder presents the field together with a flag telling whether it sits in the 6-bit source slot or in the 5-bit destination slot. It also presents the current register file, the stack pointer, program counter and extra register, and the word that would follow in the instruction stream.

One registered cycle later the block returns the result. The result holds a legality flag and a one-hot operand kind. It also holds the selected register index, the effective memory address or the operand value, and whether a write to the operand is kept. It gives the added cycle cost and a request to consume the next instruction word, with the fetch address and the advanced program counter. For stack forms it gives the new stack pointer. One stack code is context-sensitive: in the destination slot it pushes (pre-decrement), and in the source slot it pops (post-increment). The upper half of the 6-bit code space encodes small signed constants.

Top module: `opaddr_unit`

## Requirements
- R1: Codes 0x00..0x07 give kind GPR (out_kind = 4'b0001) with out_reg_sel equal to the code and out_value equal to that register (order A,B,C,X,Y,Z,I,J = index 0..7). The operand is writable, with no extra cycle and no fetch.
- R2: Codes 0x08..0x0f give kind MEM (4'b0010), with out_addr equal to the value of register (code-8), writable, with no extra cycle.
- R3: Codes 0x10..0x17 give kind MEM with out_addr = register(code-16) + next word, modulo 2^16. They request a fetch and cost one extra cycle.
- R4: Code 0x18 in the destination slot is a push: out_addr = SP-1 (mod 2^16), out_sp_next = SP-1, out_sp_we = 1.
- R5: Code 0x18 in the source slot is a pop: out_addr = SP, out_sp_next = SP+1 (mod 2^16), out_sp_we = 1.
- R6: Code 0x19 gives MEM at SP with out_sp_we = 0. Code 0x1a gives MEM at SP + next word, with a fetch and one extra cycle.
- R7: Codes 0x1b, 0x1c and 0x1d give kind SPR (4'b1000) with out_spec_sel 0, 1, 2 and out_value equal to SP, PC and EX respectively. They are writable.
- R8: Code 0x1e gives MEM at the next word. Code 0x1f gives kind LIT (4'b0100) with out_value = next word and out_writable = 0. Both fetch and cost one extra cycle.
- R9: Codes 0x20..0x3f in the source slot give kind LIT with out_value = code - 0x21 (0x20 gives 0xffff, 0x3f gives 0x001e). They are not writable, with no fetch.
- R10: Whenever a next word is used, out_fetch = 1, out_extra = 1, out_fetch_addr = PC and out_pc_next = PC+1. Otherwise out_fetch = 0 and out_extra = 0.
- R11: A destination-slot field with bit 5 set gives out_legal = 0, out_kind = 0, and no SP write and no fetch.
- R12: All outputs are registered. Results appear on the clock edge after req_valid is sampled high. With no request, out_valid = 0 and every other output is zero. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Field and context are valid this cycle |
| slot_is_a | input | 1 | 1 = source slot (6-bit), 0 = destination slot (5-bit) |
| field | input | 6 | Operand code |
| regs_flat | input | 128 | General registers, register i at bits [16i+15:16i] |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Current program counter |
| ex_in | input | 16 | Current extra register |
| next_word | input | 16 | Word at PC in the instruction stream |
| out_valid | output | 1 | Result present |
| out_legal | output | 1 | Code is legal for its slot |
| out_kind | output | 4 | One-hot kind: GPR, MEM, LIT, SPR (bit 0..3) |
| out_reg_sel | output | 3 | Selected general register |
| out_spec_sel | output | 2 | Special register: 0 SP, 1 PC, 2 EX |
| out_addr | output | 16 | Effective memory address (MEM only, else 0) |
| out_value | output | 16 | Operand value (GPR, SPR, LIT, else 0) |
| out_writable | output | 1 | A write to this operand takes effect |
| out_extra | output | 1 | One added cycle |
| out_fetch | output | 1 | Consume the next instruction word |
| out_fetch_addr | output | 16 | Address of that word (PC) |
| out_pc_next | output | 16 | PC after the fetch |
| out_sp_we | output | 1 | Stack pointer update |
| out_sp_next | output | 16 | New stack pointer |

## Verification
Every result is due exactly one rising edge after the request is sampled, because a single output register stage sits between the request and the outputs. The bench drives the field and context on a falling edge and reads the outputs on the next falling edge. That read lands after the one capturing edge and before the next request can disturb them. Back-to-back requests are checked on consecutive falling edges to show that each result replaces the previous one without a gap. An idle cycle after a request is checked for all-zero outputs.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  localparam int WORD_W    = 16;
  localparam int FIELD_W   = 6;
  localparam int NUM_GPR   = 8;
  localparam int GPR_SEL_W = $clog2(NUM_GPR);
  localparam int KIND_W    = 4;
  localparam int SPR_W     = 2;
  localparam logic [WORD_W-1:0] LIT_BIAS = WORD_W'(33);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [KIND_W-1:0] {
    KIND_NONE = 4'b0000,
    KIND_GPR  = 4'b0001,
    KIND_MEM  = 4'b0010,
    KIND_LIT  = 4'b0100,
    KIND_SPR  = 4'b1000
  } opnd_kind_e;

  typedef enum logic [SPR_W-1:0] {
    SPR_SP = 2'd0,
    SPR_PC = 2'd1,
    SPR_EX = 2'd2
  } spr_sel_e;

  typedef enum logic [3:0] {
    AM_GPR,
    AM_GPR_IND,
    AM_GPR_DISP,
    AM_STACK,
    AM_PEEK,
    AM_PICK,
    AM_SPR,
    AM_ABS,
    AM_IMM_WORD,
    AM_SHORT_LIT,
    AM_BAD
  } amode_e;

  typedef struct packed {
    logic                 legal;
    opnd_kind_e           kind;
    logic [GPR_SEL_W-1:0] gpr;
    spr_sel_e             spr;
    word_t                addr;
    word_t                value;
    logic                 writable;
    logic                 extra;
    logic                 fetch;
    word_t                fetch_addr;
    word_t                pc_next;
    logic                 sp_we;
    word_t                sp_next;
  } opnd_res_t;

  function automatic word_t wrap_add(input word_t a, input word_t b);
    return a + b;
  endfunction

  function automatic word_t short_lit(input logic [FIELD_W-1:0] code);
    return WORD_W'(code) - LIT_BIAS;
  endfunction

endpackage

// File: rtl/opaddr_gpr_mux.sv
module opaddr_gpr_mux
  import opaddr_pkg::*;
#(
  parameter int N = NUM_GPR,
  parameter int W = WORD_W,
  localparam int SW = $clog2(N)
) (
  input  logic [N*W-1:0] regs_flat,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   val
);
  logic [W-1:0] regs_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign regs_arr[i] = regs_flat[i*W +: W];
  end

  assign val = regs_arr[sel];
endmodule

// File: rtl/opaddr_decode.sv
module opaddr_decode
  import opaddr_pkg::*;
(
  input  logic                 slot_is_a,
  input  logic [FIELD_W-1:0]   field,
  output amode_e               amode,
  output logic [GPR_SEL_W-1:0] gpr_sel,
  output spr_sel_e             spr_sel
);
  always_comb begin
    amode   = AM_BAD;
    gpr_sel = field[GPR_SEL_W-1:0];
    spr_sel = SPR_SP;
    if (field[5]) begin
      amode = slot_is_a ? AM_SHORT_LIT : AM_BAD;
    end else begin
      unique case (field[4:3])
        2'd0: amode = AM_GPR;
        2'd1: amode = AM_GPR_IND;
        2'd2: amode = AM_GPR_DISP;
        default: begin
          unique case (field[2:0])
            3'd0: amode = AM_STACK;
            3'd1: amode = AM_PEEK;
            3'd2: amode = AM_PICK;
            3'd3: begin amode = AM_SPR; spr_sel = SPR_SP; end
            3'd4: begin amode = AM_SPR; spr_sel = SPR_PC; end
            3'd5: begin amode = AM_SPR; spr_sel = SPR_EX; end
            3'd6: amode = AM_ABS;
            default: amode = AM_IMM_WORD;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/opaddr_calc.sv
module opaddr_calc
  import opaddr_pkg::*;
(
  input  amode_e               amode,
  input  logic                 slot_is_a,
  input  logic [FIELD_W-1:0]   field,
  input  logic [GPR_SEL_W-1:0] gpr_sel,
  input  spr_sel_e             spr_sel,
  input  word_t                gpr_val,
  input  word_t                sp_in,
  input  word_t                pc_in,
  input  word_t                ex_in,
  input  word_t                next_word,
  output opnd_res_t            res
);
  word_t spr_val;

  always_comb begin
    unique case (spr_sel)
      SPR_PC:  spr_val = pc_in;
      SPR_EX:  spr_val = ex_in;
      default: spr_val = sp_in;
    endcase
  end

  always_comb begin
    res       = '0;
    res.legal = 1'b1;
    unique case (amode)
      AM_GPR: begin
        res.kind = KIND_GPR; res.gpr = gpr_sel;
        res.value = gpr_val; res.writable = 1'b1;
      end
      AM_GPR_IND: begin
        res.kind = KIND_MEM; res.gpr = gpr_sel;
        res.addr = gpr_val; res.writable = 1'b1;
      end
      AM_GPR_DISP: begin
        res.kind = KIND_MEM; res.gpr = gpr_sel;
        res.addr = wrap_add(gpr_val, next_word);
        res.writable = 1'b1; res.fetch = 1'b1;
      end
      AM_STACK: begin
        res.kind = KIND_MEM; res.writable = 1'b1; res.sp_we = 1'b1;
        if (slot_is_a) begin
          res.addr    = sp_in;
          res.sp_next = wrap_add(sp_in, word_t'(1));
        end else begin
          res.addr    = wrap_add(sp_in, '1);
          res.sp_next = wrap_add(sp_in, '1);
        end
      end
      AM_PEEK: begin
        res.kind = KIND_MEM; res.addr = sp_in; res.writable = 1'b1;
      end
      AM_PICK: begin
        res.kind = KIND_MEM; res.addr = wrap_add(sp_in, next_word);
        res.writable = 1'b1; res.fetch = 1'b1;
      end
      AM_SPR: begin
        res.kind = KIND_SPR; res.spr = spr_sel;
        res.value = spr_val; res.writable = 1'b1;
      end
      AM_ABS: begin
        res.kind = KIND_MEM; res.addr = next_word;
        res.writable = 1'b1; res.fetch = 1'b1;
      end
      AM_IMM_WORD: begin
        res.kind = KIND_LIT; res.value = next_word; res.fetch = 1'b1;
      end
      AM_SHORT_LIT: begin
        res.kind = KIND_LIT; res.value = short_lit(field);
      end
      default: res = '0;
    endcase
    if (res.fetch) begin
      res.extra      = 1'b1;
      res.fetch_addr = pc_in;
      res.pc_next    = wrap_add(pc_in, word_t'(1));
    end
  end
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       slot_is_a,
  input  logic [FIELD_W-1:0]         field,
  input  logic [NUM_GPR*WORD_W-1:0]  regs_flat,
  input  logic [WORD_W-1:0]          sp_in,
  input  logic [WORD_W-1:0]          pc_in,
  input  logic [WORD_W-1:0]          ex_in,
  input  logic [WORD_W-1:0]          next_word,
  output logic                       out_valid,
  output logic                       out_legal,
  output logic [KIND_W-1:0]          out_kind,
  output logic [GPR_SEL_W-1:0]       out_reg_sel,
  output logic [SPR_W-1:0]           out_spec_sel,
  output logic [WORD_W-1:0]          out_addr,
  output logic [WORD_W-1:0]          out_value,
  output logic                       out_writable,
  output logic                       out_extra,
  output logic                       out_fetch,
  output logic [WORD_W-1:0]          out_fetch_addr,
  output logic [WORD_W-1:0]          out_pc_next,
  output logic                       out_sp_we,
  output logic [WORD_W-1:0]          out_sp_next
);
  amode_e               amode;
  logic [GPR_SEL_W-1:0] gpr_sel;
  spr_sel_e             spr_sel;
  word_t                gpr_val;
  opnd_res_t            res_d;
  opnd_res_t            res_q;
  logic                 valid_q;

  // named events for the checker
  logic ev_push, ev_pop, ev_fetch, ev_bad;
  assign ev_push  = req_valid && (amode == AM_STACK) && !slot_is_a;
  assign ev_pop   = req_valid && (amode == AM_STACK) &&  slot_is_a;
  assign ev_fetch = req_valid && res_d.fetch;
  assign ev_bad   = req_valid && (amode == AM_BAD);

  opaddr_decode u_decode (
    .slot_is_a (slot_is_a),
    .field     (field),
    .amode     (amode),
    .gpr_sel   (gpr_sel),
    .spr_sel   (spr_sel)
  );

  opaddr_gpr_mux #(.N(NUM_GPR), .W(WORD_W)) u_gpr_mux (
    .regs_flat (regs_flat),
    .sel       (gpr_sel),
    .val       (gpr_val)
  );

  opaddr_calc u_calc (
    .amode     (amode),
    .slot_is_a (slot_is_a),
    .field     (field),
    .gpr_sel   (gpr_sel),
    .spr_sel   (spr_sel),
    .gpr_val   (gpr_val),
    .sp_in     (sp_in),
    .pc_in     (pc_in),
    .ex_in     (ex_in),
    .next_word (next_word),
    .res       (res_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= req_valid;
      res_q   <= req_valid ? res_d : '0;
    end
  end

  assign out_valid      = valid_q;
  assign out_legal      = res_q.legal;
  assign out_kind       = res_q.kind;
  assign out_reg_sel    = res_q.gpr;
  assign out_spec_sel   = res_q.spr;
  assign out_addr       = res_q.addr;
  assign out_value      = res_q.value;
  assign out_writable   = res_q.writable;
  assign out_extra      = res_q.extra;
  assign out_fetch      = res_q.fetch;
  assign out_fetch_addr = res_q.fetch_addr;
  assign out_pc_next    = res_q.pc_next;
  assign out_sp_we      = res_q.sp_we;
  assign out_sp_next    = res_q.sp_next;
endmodule

// File: rtl/opaddr_unit_chk.sv
module opaddr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [15:0] sp_in,
  input logic [15:0] pc_in,
  input logic        ev_push,
  input logic        ev_pop,
  input logic        ev_fetch,
  input logic        ev_bad,
  input logic        out_valid,
  input logic        out_legal,
  input logic [3:0]  out_kind,
  input logic [15:0] out_addr,
  input logic        out_writable,
  input logic        out_extra,
  input logic        out_fetch,
  input logic [15:0] out_fetch_addr,
  input logic [15:0] out_pc_next,
  input logic        out_sp_we,
  input logic [15:0] out_sp_next
);
  p_req_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);
  p_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && out_kind == 4'b0 && !out_sp_we && !out_fetch));
  p_kind_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_legal) |-> ($countones(out_kind) == 1));
  p_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push |=> (out_sp_we && out_sp_next == 16'($past(sp_in) - 16'd1)
                 && out_addr == out_sp_next));
  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |=> (out_sp_we && out_addr == $past(sp_in)
                && out_sp_next == 16'($past(sp_in) + 16'd1)));
  p_fetch_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fetch |=> (out_fetch && out_extra && out_fetch_addr == $past(pc_in)
                  && out_pc_next == 16'(out_fetch_addr + 16'd1)));
  p_cost_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_extra == out_fetch));
  p_lit_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == 4'b0100) |-> !out_writable);
  p_bad_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad |=> (!out_legal && out_kind == 4'b0 && !out_sp_we && !out_fetch));
endmodule

bind opaddr_unit opaddr_unit_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .sp_in          (sp_in),
  .pc_in          (pc_in),
  .ev_push        (ev_push),
  .ev_pop         (ev_pop),
  .ev_fetch       (ev_fetch),
  .ev_bad         (ev_bad),
  .out_valid      (out_valid),
  .out_legal      (out_legal),
  .out_kind       (out_kind),
  .out_addr       (out_addr),
  .out_writable   (out_writable),
  .out_extra      (out_extra),
  .out_fetch      (out_fetch),
  .out_fetch_addr (out_fetch_addr),
  .out_pc_next    (out_pc_next),
  .out_sp_we      (out_sp_we),
  .out_sp_next    (out_sp_next)
);

// File: tb/opaddr_unit_tb_top.sv
`timescale 1ns/1ps
module opaddr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        slot_is_a = 1'b0;
  logic [5:0]  field = '0;
  logic [127:0] regs_flat;
  logic [15:0] sp_in = 16'h0400;
  logic [15:0] pc_in = 16'h0200;
  logic [15:0] ex_in = 16'h0055;
  logic [15:0] next_word = 16'h0030;
  logic        out_valid, out_legal, out_writable, out_extra, out_fetch, out_sp_we;
  logic [3:0]  out_kind;
  logic [2:0]  out_reg_sel;
  logic [1:0]  out_spec_sel;
  logic [15:0] out_addr, out_value, out_fetch_addr, out_pc_next, out_sp_next;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_regs
    assign regs_flat[g*16 +: 16] = 16'h1000 + 16'(g);
  end

  opaddr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .slot_is_a(slot_is_a),
    .field(field), .regs_flat(regs_flat), .sp_in(sp_in), .pc_in(pc_in),
    .ex_in(ex_in), .next_word(next_word), .out_valid(out_valid),
    .out_legal(out_legal), .out_kind(out_kind), .out_reg_sel(out_reg_sel),
    .out_spec_sel(out_spec_sel), .out_addr(out_addr), .out_value(out_value),
    .out_writable(out_writable), .out_extra(out_extra), .out_fetch(out_fetch),
    .out_fetch_addr(out_fetch_addr), .out_pc_next(out_pc_next),
    .out_sp_we(out_sp_we), .out_sp_next(out_sp_next)
  );

  typedef struct packed {
    logic        slot_a;
    logic [5:0]  code;
    logic [3:0]  kind;
    logic        legal;
    logic [15:0] addr;
    logic [15:0] value;
    logic        wr;
    logic        fetch;
    logic        sp_we;
    logic [15:0] sp_next;
    logic [7:0]  req;
  } vec_t;

  // context: reg i = 0x1000+i, SP 0x0400, PC 0x0200, EX 0x0055, next word 0x0030
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'h02, 4'h1, 1'b1, 16'h0000, 16'h1002, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd1},  // R1
    '{1'b0, 6'h0f, 4'h2, 1'b1, 16'h1007, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd2},  // R2
    '{1'b1, 6'h13, 4'h2, 1'b1, 16'h1033, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 8'd3},  // R3
    '{1'b0, 6'h18, 4'h2, 1'b1, 16'h03ff, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h03ff, 8'd4},  // R4
    '{1'b1, 6'h18, 4'h2, 1'b1, 16'h0400, 16'h0000, 1'b1, 1'b0, 1'b1, 16'h0401, 8'd5},  // R5
    '{1'b1, 6'h19, 4'h2, 1'b1, 16'h0400, 16'h0000, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd6},  // R6
    '{1'b0, 6'h1a, 4'h2, 1'b1, 16'h0430, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 8'd6},  // R6
    '{1'b1, 6'h1b, 4'h8, 1'b1, 16'h0000, 16'h0400, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd7},  // R7
    '{1'b0, 6'h1c, 4'h8, 1'b1, 16'h0000, 16'h0200, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd7},  // R7
    '{1'b1, 6'h1d, 4'h8, 1'b1, 16'h0000, 16'h0055, 1'b1, 1'b0, 1'b0, 16'h0000, 8'd7},  // R7
    '{1'b0, 6'h1e, 4'h2, 1'b1, 16'h0030, 16'h0000, 1'b1, 1'b1, 1'b0, 16'h0000, 8'd8},  // R8
    '{1'b0, 6'h1f, 4'h4, 1'b1, 16'h0000, 16'h0030, 1'b0, 1'b1, 1'b0, 16'h0000, 8'd8},  // R8
    '{1'b1, 6'h20, 4'h4, 1'b1, 16'h0000, 16'hffff, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 6'h21, 4'h4, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b1, 6'h3f, 4'h4, 1'b1, 16'h0000, 16'h001e, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd9},  // R9
    '{1'b0, 6'h25, 4'h0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 8'd11}  // R11
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge; result is captured at the next rising edge and read at the falling edge after it
  task automatic issue(input logic a, input logic [5:0] f);
    @(negedge clk);
    req_valid = 1'b1; slot_is_a = a; field = f;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset valid", 32'(out_valid), 32'd0);
    chk("R12 reset kind",  32'(out_kind),  32'd0);
    chk("R12 reset sp_we", 32'(out_sp_we), 32'd0);
    chk("R12 reset fetch", 32'(out_fetch), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].slot_a, VECS[i].code);
      chk($sformatf("R%0d vec%0d valid", VECS[i].req, i), 32'(out_valid), 32'd1);
      chk($sformatf("R%0d vec%0d legal", VECS[i].req, i), 32'(out_legal), 32'(VECS[i].legal));
      chk($sformatf("R%0d vec%0d kind",  VECS[i].req, i), 32'(out_kind),  32'(VECS[i].kind));
      chk($sformatf("R%0d vec%0d addr",  VECS[i].req, i), 32'(out_addr),  32'(VECS[i].addr));
      chk($sformatf("R%0d vec%0d value", VECS[i].req, i), 32'(out_value), 32'(VECS[i].value));
      chk($sformatf("R%0d vec%0d wr",    VECS[i].req, i), 32'(out_writable), 32'(VECS[i].wr));
      chk($sformatf("R10 vec%0d fetch", i), 32'(out_fetch), 32'(VECS[i].fetch));
      chk($sformatf("R10 vec%0d extra", i), 32'(out_extra), 32'(VECS[i].fetch));
      if (VECS[i].fetch) begin
        chk($sformatf("R10 vec%0d fetch_addr", i), 32'(out_fetch_addr), 32'h0200);
        chk($sformatf("R10 vec%0d pc_next", i), 32'(out_pc_next), 32'h0201);
      end
      chk($sformatf("R%0d vec%0d sp_we", VECS[i].req, i), 32'(out_sp_we), 32'(VECS[i].sp_we));
      if (VECS[i].sp_we)
        chk($sformatf("R%0d vec%0d sp_next", VECS[i].req, i), 32'(out_sp_next), 32'(VECS[i].sp_next));
    end

    // R12: idle cycle clears outputs
    @(negedge clk);
    chk("R12 idle valid", 32'(out_valid), 32'd0);
    chk("R12 idle value", 32'(out_value), 32'd0);

    // R1: register select index
    issue(1'b1, 6'h06);
    chk("R1 reg_sel", 32'(out_reg_sel), 32'd6);
    chk("R1 value I", 32'(out_value), 32'h1006);
    // R7: special select for EX
    issue(1'b0, 6'h1d);
    chk("R7 spec_sel", 32'(out_spec_sel), 32'd2);

    // R3: displacement wraps
    next_word = 16'hfff8;
    issue(1'b1, 6'h17);
    chk("R3 wrap addr", 32'(out_addr), 32'h0fff);
    next_word = 16'h0030;

    // R4: push at SP 0 wraps
    sp_in = 16'h0000;
    issue(1'b0, 6'h18);
    chk("R4 wrap addr", 32'(out_addr), 32'hffff);
    chk("R4 wrap sp_next", 32'(out_sp_next), 32'hffff);

    // R5: pop at SP 0xffff wraps
    sp_in = 16'hffff;
    issue(1'b1, 6'h18);
    chk("R5 wrap addr", 32'(out_addr), 32'hffff);
    chk("R5 wrap sp_next", 32'(out_sp_next), 32'h0000);
    sp_in = 16'h0400;

    // R11: top destination code illegal, no side effects
    issue(1'b0, 6'h3f);
    chk("R11 legal", 32'(out_legal), 32'd0);
    chk("R11 sp_we", 32'(out_sp_we), 32'd0);
    chk("R11 fetch", 32'(out_fetch), 32'd0);
    chk("R11 value", 32'(out_value), 32'd0);

    // R12: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; slot_is_a = 1'b1; field = 6'h1f;
    @(negedge clk);
    chk("R12 b2b first kind", 32'(out_kind), 32'h4);
    field = 6'h03;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 b2b second valid", 32'(out_valid), 32'd1);
    chk("R12 b2b second value", 32'(out_value), 32'h1003);
    chk("R12 b2b second fetch", 32'(out_fetch), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule